// File: doc/BRIEF.md
# Processor Power-Down Mode Controller

This block puts a processor core into one of three sleep depths and brings it back out. Software writes a 6-bit sleep code into the control register. After a fixed entry delay, the block lowers up to three clock controls: the gate on the core clock, the enable on the PLL output clock and the enable on the PLL reference input.

In the light sleep depth, only the core clock is gated. The interrupt logic and memory traffic keep running, so an interrupt can wake the core. The code selects the wake policy: either only enabled interrupts wake the core, or any pending interrupt does. On wake, the block pulses `wake_pulse` and sets `wake_isr`. The value of `wake_isr` tells the core whether to run the service routine before resuming at the instruction where sleep began.

The two deeper depths ignore all interrupts and end only through a device reset. A reset taken from the deepest depth does not reopen the clocks at once. It keeps the core and PLL output gated for a programmable number of cycles while the PLL relocks. `clk` is the always-running clock from the reference domain.

Top module: `pwrdn_ctrl`

## Requirements
- R1: A cycle with `rst` high, taken from any state other than the deepest sleep or the relock wait, leaves `field_q` = 000000, `cpu_clk_en` = `pll_out_en` = `pll_ref_en` = 1, `wake_pulse` = 0 and `wake_isr` = 0 after that edge.
- R2: A write whose code is not one of 000000, 001001, 010001, 011010 or 011100 is ignored, and `field_q` keeps its previous value.
- R3: A write of 001001 or 010001 is stored in `field_q` at the write edge. `cpu_clk_en` falls exactly 8 edges after the write edge (parameter `ENTRY_DLY`), and both PLL enables stay 1. Interrupts seen during those 8 cycles are ignored.
- R4: Under code 001001, a pending non-enabled interrupt (`irq_nen_pend`) does not wake the core, and an enabled interrupt (`irq_en_pend`) does.
- R5: Under code 010001, either interrupt wakes the core. `wake_isr` is 1 if `irq_en_pend` was high in the waking cycle and 0 if only `irq_nen_pend` was high.
- R6: On wake, after the edge that samples the interrupt, `cpu_clk_en` = 1, `field_q` = 000000, and `wake_pulse` = 1 for exactly one cycle. `wake_isr` then holds its value until the next wake or reset.
- R7: Code 011010, 8 edges after the write, gives `cpu_clk_en` = 0, `pll_out_en` = 0 and `pll_ref_en` = 1. Interrupts are then ignored, and a reset returns all enables to 1 at the reset edge.
- R8: Code 011100, 8 edges after the write, drives all three enables to 0, and interrupts are ignored.
- R9: A reset taken from code 011100 leaves `pll_ref_en` = 1, `field_q` = 000000 and `cpu_clk_en` = `pll_out_en` = 0 for `relock_len` edges counted from the reset edge. A further reset during that wait restarts the count.
- R10: Writes made while the block is not in normal operation (entering, asleep or relocking) are ignored.
- R11: Writing 000000 causes no power-down, and all enables stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock from the reference domain |
| rst | input | 1 | Synchronous active-high device reset |
| field_wr | input | 1 | Write strobe for the sleep-code field |
| field_wdata | input | 6 | Sleep code being written |
| irq_en_pend | input | 1 | An enabled interrupt is pending |
| irq_nen_pend | input | 1 | A non-enabled interrupt is pending |
| relock_len | input | RELOCK_W | Relock wait length in cycles |
| field_q | output | 6 | Current sleep code |
| cpu_clk_en | output | 1 | Core clock-gate enable |
| pll_out_en | output | 1 | PLL output clock enable |
| pll_ref_en | output | 1 | PLL reference input enable |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_isr | output | 1 | 1: run the service routine before resuming |

## Verification
The hardest situation to reach is a reset that arrives in the middle of the relock wait, because that wait exists only after the deepest sleep has been entered and then left through reset. The stimulus writes 011100, waits out the entry delay, resets, and lets two relock cycles pass. It then resets again and counts the full wait from the second reset edge. The wake policies are also checked with both interrupt lines raised in the same cycle, which shows that an enabled interrupt takes precedence in `wake_isr`.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  localparam logic [5:0] PD_CODE_NONE    = 6'b000000;
  localparam logic [5:0] PD_CODE_L_EN    = 6'b001001;
  localparam logic [5:0] PD_CODE_L_ANY   = 6'b010001;
  localparam logic [5:0] PD_CODE_MID     = 6'b011010;
  localparam logic [5:0] PD_CODE_DEEP    = 6'b011100;

  typedef enum logic [2:0] {
    ST_RUN, ST_ENTER, ST_LIGHT, ST_MID, ST_DEEP, ST_RELOCK
  } pd_state_e;

  typedef struct packed {
    logic valid;
    logic none;
    logic light;
    logic light_any;
    logic mid;
    logic deep;
  } pd_dec_t;
endpackage

// File: rtl/pwrdn_decode.sv
module pwrdn_decode
  import pwrdn_pkg::*;
(
  input  logic [5:0] code,
  output pd_dec_t    dec
);
  always_comb begin
    dec = '0;
    case (code)
      PD_CODE_NONE:  begin dec.valid = 1'b1; dec.none = 1'b1; end
      PD_CODE_L_EN:  begin dec.valid = 1'b1; dec.light = 1'b1; end
      PD_CODE_L_ANY: begin dec.valid = 1'b1; dec.light = 1'b1; dec.light_any = 1'b1; end
      PD_CODE_MID:   begin dec.valid = 1'b1; dec.mid = 1'b1; end
      PD_CODE_DEEP:  begin dec.valid = 1'b1; dec.deep = 1'b1; end
      default:       dec = '0;
    endcase
  end
endmodule

// File: rtl/pwrdn_timer.sv
module pwrdn_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;
  logic [W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign done    = cnt_inc >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (clr)
      cnt <= '0;
    else if (en && !done)
      cnt <= cnt_inc[W-1:0];
  end
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int ENTRY_DLY = 8,
  parameter int RELOCK_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                field_wr,
  input  logic [5:0]          field_wdata,
  input  logic                irq_en_pend,
  input  logic                irq_nen_pend,
  input  logic [RELOCK_W-1:0] relock_len,
  output logic [5:0]          field_q,
  output logic                cpu_clk_en,
  output logic                pll_out_en,
  output logic                pll_ref_en,
  output logic                wake_pulse,
  output logic                wake_isr
);
  localparam int EW = $clog2(ENTRY_DLY + 1);
  localparam logic [EW-1:0] ENTRY_LIM = EW'(ENTRY_DLY);

  pd_state_e st_q, st_d;
  pd_dec_t   wr_dec, q_dec;
  logic [5:0] field_d;
  logic wake_d, isr_d, ent_done, rlk_done;

  pwrdn_decode u_dec_wr (.code(field_wdata), .dec(wr_dec));
  pwrdn_decode u_dec_q  (.code(field_q),     .dec(q_dec));

  pwrdn_timer #(.W(EW)) u_entry (
    .clk(clk), .clr(st_q != ST_ENTER), .en(1'b1),
    .limit(ENTRY_LIM), .done(ent_done)
  );

  pwrdn_timer #(.W(RELOCK_W)) u_relock (
    .clk(clk), .clr(rst || (st_q != ST_RELOCK)), .en(1'b1),
    .limit(relock_len), .done(rlk_done)
  );

  always_comb begin
    st_d    = st_q;
    field_d = field_q;
    wake_d  = 1'b0;
    isr_d   = wake_isr;
    case (st_q)
      ST_RUN: begin
        if (field_wr && wr_dec.valid) begin
          field_d = field_wdata;
          if (!wr_dec.none) st_d = ST_ENTER;
        end
      end
      ST_ENTER: begin
        if (ent_done)
          st_d = q_dec.light ? ST_LIGHT : (q_dec.mid ? ST_MID : ST_DEEP);
      end
      ST_LIGHT: begin
        if (irq_en_pend || (q_dec.light_any && irq_nen_pend)) begin
          st_d    = ST_RUN;
          field_d = PD_CODE_NONE;
          wake_d  = 1'b1;
          isr_d   = irq_en_pend;
        end
      end
      ST_RELOCK: begin
        if (rlk_done) st_d = ST_RUN;
      end
      default: ;
    endcase
    if (rst) begin
      st_d    = (st_q == ST_DEEP || st_q == ST_RELOCK) ? ST_RELOCK : ST_RUN;
      field_d = PD_CODE_NONE;
      wake_d  = 1'b0;
      isr_d   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    st_q       <= st_d;
    field_q    <= field_d;
    wake_pulse <= wake_d;
    wake_isr   <= isr_d;
    cpu_clk_en <= (st_d == ST_RUN) || (st_d == ST_ENTER);
    pll_out_en <= !((st_d == ST_MID) || (st_d == ST_DEEP) || (st_d == ST_RELOCK));
    pll_ref_en <= (st_d != ST_DEEP);
  end

  assert_reserved_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && field_wr && !wr_dec.valid) |=> $stable(field_q));
  assert_enonly_nowake_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LIGHT && !q_dec.light_any && !irq_en_pend) |=> !wake_pulse);
  assert_wake_single_R6: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);
  assert_wake_restores_R6: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (cpu_clk_en && field_q == PD_CODE_NONE));
  assert_mid_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_MID) |=> (st_q == ST_MID && !cpu_clk_en && !pll_out_en));
  assert_deep_gated_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DEEP) |-> (!pll_ref_en && !pll_out_en && !cpu_clk_en));
  assert_relock_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RELOCK) |-> (pll_ref_en && !cpu_clk_en && !pll_out_en));
  assert_sleep_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LIGHT && !irq_en_pend && !irq_nen_pend) |=> $stable(field_q));
endmodule

// File: tb/sim_pwrdn_ctrl.sv
module sim_pwrdn_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic field_wr = 1'b0;
  logic [5:0] field_wdata = '0;
  logic irq_en_pend = 1'b0, irq_nen_pend = 1'b0;
  logic [15:0] relock_len = 16'd5;
  logic [5:0] field_q;
  logic cpu_clk_en, pll_out_en, pll_ref_en, wake_pulse, wake_isr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic [4:0] en;
    logic [5:0] fld;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  pwrdn_ctrl #(.ENTRY_DLY(8), .RELOCK_W(16)) u0 (
    .clk(clk), .rst(rst), .field_wr(field_wr), .field_wdata(field_wdata),
    .irq_en_pend(irq_en_pend), .irq_nen_pend(irq_nen_pend), .relock_len(relock_len),
    .field_q(field_q), .cpu_clk_en(cpu_clk_en), .pll_out_en(pll_out_en),
    .pll_ref_en(pll_ref_en), .wake_pulse(wake_pulse), .wake_isr(wake_isr)
  );

  // monitor: compares outputs 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        exp_t e;
        logic [4:0] act;
        e = q.pop_front();
        act = {cpu_clk_en, pll_out_en, pll_ref_en, wake_pulse, wake_isr};
        checks++;
        if (act !== e.en || field_q !== e.fld) begin
          errors++;
          $display("FAIL %s: act en=%b fld=%b exp en=%b fld=%b",
                   e.req, act, field_q, e.en, e.fld);
        end
      end
    end
  end

  // driver: push expected outputs after the next edge, then advance one cycle
  task automatic cyc(input string r, input logic [4:0] en, input logic [5:0] f);
    exp_t e;
    e.req = r; e.en = en; e.fld = f;
    q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b0;
    cyc("R1", 5'b11100, 6'b000000);
    // R2 reserved code
    field_wr = 1'b1; field_wdata = 6'b000111;
    cyc("R2", 5'b11100, 6'b000000);
    field_wdata = 6'b011011;
    cyc("R2", 5'b11100, 6'b000000);
    // R11 no power-down
    field_wdata = 6'b000000;
    cyc("R11", 5'b11100, 6'b000000);
    field_wr = 1'b0;
    for (int i = 0; i < 10; i++) cyc("R11", 5'b11100, 6'b000000);
    // R3 / R4: enabled-only light sleep
    field_wr = 1'b1; field_wdata = 6'b001001;
    cyc("R3", 5'b11100, 6'b001001);
    field_wr = 1'b0;
    for (int i = 1; i < 8; i++) begin
      irq_en_pend = (i == 3);
      cyc("R3", 5'b11100, 6'b001001);
    end
    irq_en_pend = 1'b0;
    cyc("R3", 5'b01100, 6'b001001);
    field_wr = 1'b1; field_wdata = 6'b011100;
    cyc("R10", 5'b01100, 6'b001001);
    field_wr = 1'b0;
    irq_nen_pend = 1'b1;
    for (int i = 0; i < 3; i++) cyc("R4", 5'b01100, 6'b001001);
    irq_nen_pend = 1'b0; irq_en_pend = 1'b1;
    cyc("R4", 5'b11111, 6'b000000);
    irq_en_pend = 1'b0;
    cyc("R6", 5'b11101, 6'b000000);
    // R5: any-interrupt policy, non-enabled wake
    field_wr = 1'b1; field_wdata = 6'b010001;
    cyc("R3", 5'b11101, 6'b010001);
    field_wr = 1'b0;
    for (int i = 1; i < 8; i++) cyc("R3", 5'b11101, 6'b010001);
    cyc("R3", 5'b01101, 6'b010001);
    irq_nen_pend = 1'b1;
    cyc("R5", 5'b11110, 6'b000000);
    irq_nen_pend = 1'b0;
    cyc("R6", 5'b11100, 6'b000000);
    // R5: both lines at once
    field_wr = 1'b1; field_wdata = 6'b010001;
    cyc("R5", 5'b11100, 6'b010001);
    field_wr = 1'b0;
    for (int i = 1; i < 9; i++) cyc("R5", (i == 8) ? 5'b01100 : 5'b11100, 6'b010001);
    irq_nen_pend = 1'b1; irq_en_pend = 1'b1;
    cyc("R5", 5'b11111, 6'b000000);
    irq_nen_pend = 1'b0; irq_en_pend = 1'b0;
    cyc("R6", 5'b11101, 6'b000000);
    // R7 middle depth
    field_wr = 1'b1; field_wdata = 6'b011010;
    cyc("R7", 5'b11101, 6'b011010);
    field_wr = 1'b0;
    for (int i = 1; i < 8; i++) cyc("R7", 5'b11101, 6'b011010);
    cyc("R7", 5'b00101, 6'b011010);
    irq_en_pend = 1'b1; irq_nen_pend = 1'b1;
    for (int i = 0; i < 3; i++) cyc("R7", 5'b00101, 6'b011010);
    irq_en_pend = 1'b0; irq_nen_pend = 1'b0;
    rst = 1'b1;
    cyc("R7", 5'b11100, 6'b000000);
    rst = 1'b0;
    // R8 / R9 deepest depth and relock
    field_wr = 1'b1; field_wdata = 6'b011100;
    cyc("R8", 5'b11100, 6'b011100);
    field_wr = 1'b0;
    for (int i = 1; i < 8; i++) cyc("R8", 5'b11100, 6'b011100);
    cyc("R8", 5'b00000, 6'b011100);
    irq_en_pend = 1'b1;
    for (int i = 0; i < 2; i++) cyc("R8", 5'b00000, 6'b011100);
    irq_en_pend = 1'b0;
    rst = 1'b1;
    cyc("R9", 5'b00100, 6'b000000);
    rst = 1'b0;
    for (int i = 1; i < 5; i++) cyc("R9", 5'b00100, 6'b000000);
    cyc("R9", 5'b11100, 6'b000000);
    // R9 restart of the wait
    field_wr = 1'b1; field_wdata = 6'b011100;
    cyc("R8", 5'b11100, 6'b011100);
    field_wr = 1'b0;
    for (int i = 1; i < 8; i++) cyc("R8", 5'b11100, 6'b011100);
    cyc("R8", 5'b00000, 6'b011100);
    rst = 1'b1;
    cyc("R9", 5'b00100, 6'b000000);
    rst = 1'b0;
    for (int i = 0; i < 2; i++) cyc("R9", 5'b00100, 6'b000000);
    rst = 1'b1;
    cyc("R9", 5'b00100, 6'b000000);
    rst = 1'b0;
    for (int i = 1; i < 5; i++) cyc("R9", 5'b00100, 6'b000000);
    cyc("R9", 5'b11100, 6'b000000);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act running exp finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule